// File: doc/BRIEF.md
# Energize-and-Hold Output Controller

This block turns eight channel bits and one shared 8-bit setting word into eight gate-drive signals for solenoid-style loads. When a channel bit goes high, that channel drives fully on for a selectable energizing time. It then drops to a chopped hold level with a duty in eighths, or it switches off. The chop period gets longer at the two lowest duties, so each pulse stays a useful width.

Three things change the profile. A timer-enable bit picks between a timed profile and a plain fully-on output. A one-cycle start strobe can end the energizing phase early. A global enable input forces every output off while it is low. The millisecond timebase and the chop slot rate come from system-clock dividers set by parameters, so a simulation can shrink real time.

Setting word fields: bit 7 is the timer enable. Bits 6:4 are the hold duty code d. Bits 3:0 are the energizing-time code.

Top module: `hold_drive_top`

## Requirements
- R1: After reset every drive bit is 0. Each drive bit is registered and reacts to its inputs one clock after they are sampled.
- R2: Timer enable set and time code nonzero: when a channel bit rises, the channel drives fully on until its time has run out, then chops at duty d. The time is counted in millisecond ticks of a shared timebase, so it lasts more than T-1 ms and at most T ms.
- R3: Timer enable set and time code 0: the channel starts chopping at duty d directly, with no fully-on phase.
- R4: Duty code d gives an on-fraction of d/8. Measured in chop slots, the period is 8 slots for d of 3 or more, 16 slots for d=2 and 32 slots for d=1. Each period starts with its on-part. Code 0 keeps the output off.
- R5: Timer enable set, time code nonzero and duty code 0: the output turns off when the energizing time expires and stays off while the bit stays high.
- R6: A start strobe that arrives while a channel is energizing moves it to chopping at duty d. This applies with the timer enable clear as well.
- R7: Timer enable clear: once the energizing time expires without a strobe, or at once if the time code is 0, the channel stays fully on. Later strobes are ignored.
- R8: While enable is low, every drive bit is 0 from the next clock on. The channel timers keep running, so when enable returns the outputs show the phase each channel has reached.
- R9: A channel bit of 0 forces that drive bit to 0 on the next clock and returns the channel to idle. The next 0-to-1 change restarts its profile from the start.
- R10: The time codes 0 to 15 map to 0, 3, 5, 10, 15, 20, 30, 50, 80, 110, 140, 170, 200, 230, 260 and 300 ms.
- R11: Channels run independently. Each follows only its own bit, under the shared setting word, strobe and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global output enable; low forces all drives off |
| chan_on | input | 8 | Per-channel on request |
| setting | input | 8 | Timer enable, hold duty code and time code |
| start_pulse | input | 1 | One-cycle strobe that ends energizing early |
| drive | output | 8 | Per-channel gate drive |

## Verification
The bench measures chop waveforms over one full 32-slot window. It counts both on-cycles and rising edges, so a design that always used the 8-slot period at low duties shows too many edges at d=1 and d=2. It probes the energizing phase inside and just beyond the shortest and longest table entries. A wrong table entry or an off-by-one expiry shows up as the wrong level at one of those sample points. It sends strobes both before and after expiry with the timer disabled, and a design that does not keep the fully-on state sticky starts chopping. It also drops enable in the middle of a profile: a design that reset the timers there would still be on when the profile should have ended.

// File: rtl/hold_drive_pkg.sv
package hold_drive_pkg;

    localparam int CODE_W  = 4;
    localparam int DUTY_W  = 3;
    localparam int NDUTY   = 1 << DUTY_W;
    localparam int SLOT_W  = DUTY_W + 2;
    localparam int MS_W    = 9;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ENERGIZE,
        PH_HOLD,
        PH_FULL,
        PH_DARK
    } phase_e;

    typedef struct packed {
        logic            tmr_en;
        logic [DUTY_W-1:0] duty;
        logic [CODE_W-1:0] tcode;
    } setting_t;

    function automatic logic [MS_W-1:0] code_to_ms(input logic [CODE_W-1:0] c);
        logic [MS_W-1:0] r;
        case (c)
            4'd0:    r = 9'd0;
            4'd1:    r = 9'd3;
            4'd2:    r = 9'd5;
            4'd3:    r = 9'd10;
            4'd4:    r = 9'd15;
            4'd5:    r = 9'd20;
            4'd6:    r = 9'd30;
            4'd7:    r = 9'd50;
            4'd8:    r = 9'd80;
            4'd9:    r = 9'd110;
            4'd10:   r = 9'd140;
            4'd11:   r = 9'd170;
            4'd12:   r = 9'd200;
            4'd13:   r = 9'd230;
            4'd14:   r = 9'd260;
            default: r = 9'd300;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hold_tick_div.sv
module hold_tick_div #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } div_t;

    div_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (d_q.cnt == LAST) begin
            d_d.cnt  = '0;
            d_d.tick = 1'b1;
        end else begin
            d_d.cnt  = d_q.cnt + 1'b1;
            d_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign tick = d_q.tick;

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        d_q.tick |=> !d_q.tick);
endmodule

// File: rtl/hold_chop_gen.sv
module hold_chop_gen
    import hold_drive_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_tick,
    output logic [NDUTY-1:0] wave
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } chop_t;

    chop_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (slot_tick) c_d.slot = c_q.slot + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    for (genvar k = 0; k < NDUTY; k++) begin : g_duty
        if (k == 0) begin : g_zero
            assign wave[k] = 1'b0;
        end else if (k == 1) begin : g_eighth
            assign wave[k] = (c_q.slot[SLOT_W-1:2] == '0);
        end else if (k == 2) begin : g_quarter
            assign wave[k] = (c_q.slot[3:2] == 2'b00);
        end else begin : g_base
            assign wave[k] = (c_q.slot[DUTY_W-1:0] < DUTY_W'(k));
        end
    end

    assert_slot_moves_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> $stable(c_q.slot));
endmodule

// File: rtl/hold_channel.sv
module hold_channel
    import hold_drive_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             on_i,
    input  setting_t         set_i,
    input  logic             start_i,
    input  logic             ms_tick_i,
    input  logic [NDUTY-1:0] wave_i,
    output logic             drive_o
);
    typedef struct packed {
        phase_e          ph;
        logic [MS_W-1:0] cnt;
        logic            prev;
        logic            out;
    } ch_t;

    ch_t s_d, s_q;
    logic raw;

    always_comb begin
        s_d      = s_q;
        s_d.prev = on_i;
        if (!on_i) begin
            s_d.ph  = PH_IDLE;
            s_d.cnt = '0;
        end else if (!s_q.prev) begin
            s_d.cnt = code_to_ms(set_i.tcode);
            if (set_i.tcode == '0) s_d.ph = set_i.tmr_en ? PH_HOLD : PH_FULL;
            else                   s_d.ph = PH_ENERGIZE;
        end else if (s_q.ph == PH_ENERGIZE) begin
            if (start_i) begin
                s_d.ph = PH_HOLD;
            end else if (ms_tick_i) begin
                if (s_q.cnt <= 9'd1) begin
                    if (!set_i.tmr_en)          s_d.ph = PH_FULL;
                    else if (set_i.duty == '0)  s_d.ph = PH_DARK;
                    else                        s_d.ph = PH_HOLD;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        end

        case (s_d.ph)
            PH_ENERGIZE, PH_FULL: raw = 1'b1;
            PH_HOLD:              raw = wave_i[set_i.duty];
            default:              raw = 1'b0;
        endcase
        s_d.out = enable_i & raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, cnt: '0, prev: 1'b0, out: 1'b0};
        else        s_q <= s_d;
    end

    assign drive_o = s_q.out;

    assert_off_when_request_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !on_i |=> !drive_o);

    assert_gate_forces_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !drive_o);

    assert_full_is_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_FULL && on_i) |=> (s_q.ph == PH_FULL));

    assert_timer_waits_for_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_ENERGIZE && s_q.prev && on_i && !ms_tick_i && !start_i)
        |=> (s_q.ph == PH_ENERGIZE && $stable(s_q.cnt)));

    assert_energize_drives_when_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_ENERGIZE && on_i && s_q.prev && enable_i && !start_i && !ms_tick_i)
        |=> drive_o);
endmodule

// File: rtl/hold_drive_top.sv
module hold_drive_top
    import hold_drive_pkg::*;
#(
    parameter int N_CH     = 8,
    parameter int MS_DIV   = 200000,
    parameter int SLOT_DIV = 500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [N_CH-1:0] chan_on,
    input  logic [7:0]      setting,
    input  logic            start_pulse,
    output logic [N_CH-1:0] drive
);
    logic             ms_tick;
    logic             slot_tick;
    logic [NDUTY-1:0] wave;
    setting_t         set_w;

    assign set_w = setting_t'(setting);

    hold_tick_div #(.DIV(MS_DIV)) u_ms_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (ms_tick)
    );

    hold_tick_div #(.DIV(SLOT_DIV)) u_slot_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (slot_tick)
    );

    hold_chop_gen u_chop (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_tick(slot_tick),
        .wave     (wave)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        hold_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable_i (enable),
            .on_i     (chan_on[i]),
            .set_i    (set_w),
            .start_i  (start_pulse),
            .ms_tick_i(ms_tick),
            .wave_i   (wave),
            .drive_o  (drive[i])
        );
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (drive == '0));
endmodule

// File: tb/hold_drive_top_bench.sv
`timescale 1ns/1ps
module hold_drive_top_bench;
    localparam int MS_DIV   = 20;
    localparam int SLOT_DIV = 2;
    localparam int WIN      = 32 * SLOT_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] chan_on = '0;
    logic [7:0] setting = '0;
    logic       start_pulse = 1'b0;
    logic [7:0] drive;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int         due;
        logic [7:0] exp;
        logic [7:0] mask;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hold_drive_top #(.N_CH(8), .MS_DIV(MS_DIV), .SLOT_DIV(SLOT_DIV)) u_hold_drive_top (
        .clk(clk), .rst_n(rst_n), .enable(enable), .chan_on(chan_on),
        .setting(setting), .start_pulse(start_pulse), .drive(drive)
    );

    // monitor: pops expected items when their cycle is reached
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if ((drive & it.mask) !== (it.exp & it.mask)) begin
                failures++;
                $display("FAIL %s: drive=%b expected=%b (mask %b)", it.tag, drive, it.exp, it.mask);
            end
        end
    end

    task automatic expect_after(input int dly, input logic [7:0] exp,
                                input logic [7:0] mask, input string tag);
        item_t it;
        it.due = cyc + dly; it.exp = exp; it.mask = mask; it.tag = tag;
        sb.push_back(it);
        repeat (dly) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic measure(input int ch, input int exp_on, input int exp_edges, input string tag);
        int on_c = 0;
        int edges = 0;
        logic first = 1'b0;
        logic prev = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (i == 0) first = drive[ch];
            else if (!prev && drive[ch]) edges++;
            if (drive[ch]) on_c++;
            prev = drive[ch];
        end
        if (!prev && first) edges++;
        chk({tag, " on-cycles"}, on_c, exp_on);
        chk({tag, " rising edges"}, edges, exp_edges);
    endtask

    task automatic go_idle();
        chan_on = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe();
        start_pulse = 1'b1;
        @(negedge clk);
        start_pulse = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        expect_after(1, 8'h00, 8'hFF, "R1 reset state");
        rst_n = 1'b1;
        enable = 1'b1;
        expect_after(5, 8'h00, 8'hFF, "R1 idle after reset");

        // R7 + R11: timer disabled, code 0, two channels fully on
        setting = 8'h00;
        chan_on = 8'b0000_1001;
        expect_after(2, 8'h09, 8'hFF, "R11 independent channels on");
        expect_after(400, 8'h09, 8'hFF, "R7 stays fully on");
        go_idle();

        // R3 + R4: direct chop at several duties
        setting = {1'b1, 3'd4, 4'd0};
        chan_on = 8'h01;
        repeat (4) @(negedge clk);
        measure(0, 32, 4, "R3 R4 duty 4/8");
        setting = {1'b1, 3'd1, 4'd0};
        repeat (2) @(negedge clk);
        measure(0, 8, 1, "R4 duty 1/8 long period");
        setting = {1'b1, 3'd2, 4'd0};
        repeat (2) @(negedge clk);
        measure(0, 16, 2, "R4 duty 2/8 mid period");
        setting = {1'b1, 3'd7, 4'd0};
        repeat (2) @(negedge clk);
        measure(0, 56, 4, "R4 duty 7/8");
        setting = {1'b1, 3'd0, 4'd0};
        repeat (2) @(negedge clk);
        measure(0, 0, 0, "R4 duty 0 off");
        go_idle();

        // R2: energize 3 ms then chop at 5/8
        setting = {1'b1, 3'd5, 4'd1};
        chan_on = 8'h01;
        expect_after(30, 8'h01, 8'h01, "R2 fully on while energizing");
        repeat (40) @(negedge clk);
        measure(0, 40, 4, "R2 hold duty 5/8 after energizing");
        go_idle();

        // R5: energize then off
        setting = {1'b1, 3'd0, 4'd1};
        chan_on = 8'h01;
        expect_after(30, 8'h01, 8'h01, "R5 on before expiry");
        expect_after(40, 8'h00, 8'h01, "R5 off after expiry");
        // R9: drop and re-raise restarts profile
        chan_on = 8'h00;
        expect_after(1, 8'h00, 8'h01, "R9 off on request low");
        chan_on = 8'h01;
        expect_after(20, 8'h01, 8'h01, "R9 restart energizes again");
        expect_after(50, 8'h00, 8'h01, "R9 restarted profile expires");
        go_idle();

        // R6: timer disabled, strobe before expiry -> chop
        setting = {1'b0, 3'd3, 4'd2};
        chan_on = 8'h01;
        expect_after(30, 8'h01, 8'h01, "R6 energizing before strobe");
        strobe();
        repeat (4) @(negedge clk);
        measure(0, 24, 4, "R6 chop after early strobe");
        go_idle();

        // R7: timer disabled, expiry without strobe -> sticky full on
        setting = {1'b0, 3'd3, 4'd2};
        chan_on = 8'h01;
        repeat (110) @(negedge clk);
        strobe();
        measure(0, WIN, 0, "R7 late strobe ignored");
        go_idle();

        // R8: enable low in mid-profile, timers keep running
        setting = {1'b1, 3'd0, 4'd1};
        chan_on = 8'h01;
        repeat (10) @(negedge clk);
        enable = 1'b0;
        expect_after(10, 8'h00, 8'hFF, "R8 forced off while disabled");
        enable = 1'b1;
        expect_after(5, 8'h01, 8'h01, "R8 resumes energizing");
        expect_after(45, 8'h00, 8'h01, "R8 timer kept running");
        go_idle();

        // R10: longest and a middle table entry
        setting = {1'b1, 3'd0, 4'd15};
        chan_on = 8'h01;
        expect_after(5950, 8'h01, 8'h01, "R10 code 15 still on near 300 ms");
        expect_after(60, 8'h00, 8'h01, "R10 code 15 off after 300 ms");
        go_idle();
        setting = {1'b1, 3'd0, 4'd8};
        chan_on = 8'h01;
        expect_after(1570, 8'h01, 8'h01, "R10 code 8 on near 80 ms");
        expect_after(40, 8'h00, 8'h01, "R10 code 8 off after 80 ms");
        go_idle();

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule